// File: doc/BRIEF.md
# Pipeline hazard and forwarding controller

This block resolves data and control hazards for a five-stage integer pipeline made of fetch, decode, execute, memory and write-back stages. Each cycle it compares the source register numbers of the instruction in decode with the destination numbers of the instructions in execute and memory. From that comparison it registers the operand-bypass multiplexer selects that the execute stage will use in the next cycle. It also detects a load whose result the following instruction needs. In that case it holds fetch and decode for one cycle and places a no-op into execute. The value then reaches execute through the write-back bypass.

A taken control transfer, reported by the memory stage, turns the fetch, decode and execute contents into no-ops. That flush costs three cycles and overrides any stall in the same cycle. Register 0 reads as zero, so it never causes a bypass or a stall. The register file writes in the first half of a cycle and reads in the second, so a producer three or more instructions older than its consumer needs no bypass.

The datapath registers, ALU and memories are outside this block. It sees only register numbers, write-enable and is-load flags, and the taken indication.

Top module: `pipe_hazard_unit`

## Requirements
- R1: If in cycle t there is no stall and no flush, and the execute stage writes (`ex_we_i`=1) a nonzero register equal to source k in decode, then in cycle t+1 `fwd_sel_o[k]` = 2'b01 (take the value from the memory stage).
- R2: If in cycle t there is no stall, no flush and no R1 match, and the memory stage writes (`mem_we_i`=1) a nonzero register equal to source k, then in cycle t+1 `fwd_sel_o[k]` = 2'b10 (take the value from the write-back stage).
- R3: When both the execute-stage and the memory-stage destinations match the same source, the select is 2'b01: the newer value wins.
- R4: A source of register 0 never produces a nonzero select and never causes a stall, whatever the destinations are.
- R5: A load-use case is a source k in decode that equals a nonzero destination of an execute-stage instruction with `ex_we_i`=1 and `ex_load_i`=1. When there is no flush, this raises `if_hold_o`, `id_hold_o` and `ex_bubble_o` in the same cycle. Otherwise all three are 0.
- R6: After a load-use stall, all selects are 2'b00 in the bubble cycle. If the load has moved on to the memory stage while the consumer is still in decode, the following cycle selects 2'b10 for that source.
- R7: When `mem_br_taken_i`=1, `if_flush_o`, `id_flush_o` and `ex_flush_o` are 1 and the hold and bubble outputs are 0 in the same cycle. All selects are 2'b00 in the next cycle. The flush outputs are 0 whenever `mem_br_taken_i`=0.
- R8: A source that matches no writing destination in execute or memory gets select 2'b00 (read the register file).
- R9: While `rst_ni` is low, all selects are 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_src_i | input | NUM_SRC*REG_W | Source register numbers of the decode-stage instruction |
| ex_rd_i | input | REG_W | Destination register of the execute-stage instruction |
| ex_we_i | input | 1 | Execute-stage instruction writes a register |
| ex_load_i | input | 1 | Execute-stage instruction is a load |
| mem_rd_i | input | REG_W | Destination register of the memory-stage instruction |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| mem_br_taken_i | input | 1 | Control transfer taken in the memory stage |
| fwd_sel_o | output | NUM_SRC*2 | Per-source bypass select for execute: 00 register file, 01 memory stage, 10 write-back stage |
| if_hold_o | output | 1 | Hold the fetch stage |
| id_hold_o | output | 1 | Hold the decode stage |
| ex_bubble_o | output | 1 | Load a no-op into execute |
| if_flush_o | output | 1 | Turn fetch contents into a no-op |
| id_flush_o | output | 1 | Turn decode contents into a no-op |
| ex_flush_o | output | 1 | Turn execute contents into a no-op |

## Verification
A corrupted select register shows at `fwd_sel_o` in the cycle after the decode comparison. If the cause was the clear path, it shows in the cycle after a bubble or flush. The error shows there even when the select is never used, so it is caught one cycle after the stimulus that set it. A fault in the stall or flush logic shows combinationally in the same cycle on the hold, bubble and flush outputs. The stimulus mixes random register numbers from a small range, so matches are frequent. It adds directed sequences for the load-use sequence, priority, register 0 and a flush that coincides with a stall.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MEM = 2'b01,
    FWD_WB  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] ex_rd_i,
  input  logic             ex_we_i,
  input  logic             ex_load_i,
  input  logic [REG_W-1:0] mem_rd_i,
  input  logic             mem_we_i,
  output logic             hit_ex_o,
  output logic             hit_ex_load_o,
  output logic             hit_mem_o
);
  logic src_nz;

  // register 0 is hard-wired to zero: never a dependency
  assign src_nz        = |src_i;
  assign hit_ex_o      = src_nz && ex_we_i && (ex_rd_i == src_i);
  assign hit_ex_load_o = hit_ex_o && ex_load_i;
  assign hit_mem_o     = src_nz && mem_we_i && (mem_rd_i == src_i);
endmodule

// File: rtl/hz_fwd_reg.sv
module hz_fwd_reg
  import hz_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       hit_ex_i,
  input  logic       hit_mem_i,
  output logic [1:0] sel_o
);
  fwd_sel_e sel_d, sel_q;

  // decode-time compare; producer in execute is in memory next cycle
  always_comb begin
    if (clr_i)          sel_d = FWD_RF;
    else if (hit_ex_i)  sel_d = FWD_MEM;
    else if (hit_mem_i) sel_d = FWD_WB;
    else                sel_d = FWD_RF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= FWD_RF;
    else         sel_q <= sel_d;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/hz_stall_flush.sv
module hz_stall_flush #(
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0] load_hit_i,
  input  logic               br_taken_i,
  output logic               if_hold_o,
  output logic               id_hold_o,
  output logic               ex_bubble_o,
  output logic               if_flush_o,
  output logic               id_flush_o,
  output logic               ex_flush_o,
  output logic               sel_clr_o
);
  logic stall;

  // a redirect discards the consumer anyway, so flush wins over stall
  assign stall       = (|load_hit_i) && !br_taken_i;
  assign if_hold_o   = stall;
  assign id_hold_o   = stall;
  assign ex_bubble_o = stall;
  assign if_flush_o  = br_taken_i;
  assign id_flush_o  = br_taken_i;
  assign ex_flush_o  = br_taken_i;
  assign sel_clr_o   = stall || br_taken_i;
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit #(
  parameter int NUM_SRC = 2,
  parameter int REG_W   = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SRC-1:0][REG_W-1:0] id_src_i,
  input  logic [REG_W-1:0]              ex_rd_i,
  input  logic                          ex_we_i,
  input  logic                          ex_load_i,
  input  logic [REG_W-1:0]              mem_rd_i,
  input  logic                          mem_we_i,
  input  logic                          mem_br_taken_i,
  output logic [NUM_SRC-1:0][1:0]       fwd_sel_o,
  output logic                          if_hold_o,
  output logic                          id_hold_o,
  output logic                          ex_bubble_o,
  output logic                          if_flush_o,
  output logic                          id_flush_o,
  output logic                          ex_flush_o
);
  logic [NUM_SRC-1:0] hit_ex, hit_ex_load, hit_mem;
  logic               sel_clr;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    hz_src_match #(.REG_W(REG_W)) match_i (
      .src_i         (id_src_i[k]),
      .ex_rd_i       (ex_rd_i),
      .ex_we_i       (ex_we_i),
      .ex_load_i     (ex_load_i),
      .mem_rd_i      (mem_rd_i),
      .mem_we_i      (mem_we_i),
      .hit_ex_o      (hit_ex[k]),
      .hit_ex_load_o (hit_ex_load[k]),
      .hit_mem_o     (hit_mem[k])
    );

    hz_fwd_reg sel_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (sel_clr),
      .hit_ex_i  (hit_ex[k]),
      .hit_mem_i (hit_mem[k]),
      .sel_o     (fwd_sel_o[k])
    );
  end

  hz_stall_flush #(.NUM_SRC(NUM_SRC)) ctl_i (
    .load_hit_i  (hit_ex_load),
    .br_taken_i  (mem_br_taken_i),
    .if_hold_o   (if_hold_o),
    .id_hold_o   (id_hold_o),
    .ex_bubble_o (ex_bubble_o),
    .if_flush_o  (if_flush_o),
    .id_flush_o  (id_flush_o),
    .ex_flush_o  (ex_flush_o),
    .sel_clr_o   (sel_clr)
  );
endmodule

// File: rtl/pipe_hazard_unit_chk.sv
module pipe_hazard_unit_chk #(
  parameter int NUM_SRC = 2,
  parameter int REG_W   = 5
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_SRC-1:0][REG_W-1:0] id_src_i,
  input logic                          mem_br_taken_i,
  input logic [NUM_SRC-1:0][1:0]       fwd_sel_o,
  input logic                          if_hold_o,
  input logic                          ex_bubble_o,
  input logic                          if_flush_o,
  input logic                          id_flush_o,
  input logic                          ex_flush_o
);
  // R7: taken transfer flushes all three younger stages and beats the stall
  p_flush_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_br_taken_i |-> (if_flush_o && id_flush_o && ex_flush_o && !if_hold_o && !ex_bubble_o));

  // R7: nothing is bypassed into the flushed execute slot
  p_flush_clears_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_br_taken_i |=> (fwd_sel_o == '0));

  // R6: the bubble carries no bypass
  p_bubble_clears_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_bubble_o |=> (fwd_sel_o == '0));

  // R4: all-zero sources never stall and never bypass
  p_zero_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_src_i == '0) |-> !ex_bubble_o);

  p_zero_src_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_src_i == '0) |=> (fwd_sel_o == '0));

  // R1: encoding 2'b11 is never produced
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_legal
    p_sel_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fwd_sel_o[k] != 2'b11);
  end
endmodule

bind pipe_hazard_unit pipe_hazard_unit_chk #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .id_src_i       (id_src_i),
  .mem_br_taken_i (mem_br_taken_i),
  .fwd_sel_o      (fwd_sel_o),
  .if_hold_o      (if_hold_o),
  .ex_bubble_o    (ex_bubble_o),
  .if_flush_o     (if_flush_o),
  .id_flush_o     (id_flush_o),
  .ex_flush_o     (ex_flush_o)
);

// File: tb/pipe_hazard_unit_tb_top.sv
`timescale 1ns/1ps
module pipe_hazard_unit_tb_top;
  localparam int NS = 2;
  localparam int RW = 5;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NS-1:0][RW-1:0] src = '0;
  logic [RW-1:0]        ex_rd = '0, mem_rd = '0;
  logic                 ex_we = 1'b0, ex_ld = 1'b0, mem_we = 1'b0, br = 1'b0;
  logic [NS-1:0][1:0]   sel;
  logic                 if_hold, id_hold, ex_bub, if_fl, id_fl, ex_fl;

  int checks = 0;
  int errors = 0;
  logic [NS-1:0][1:0] exp_sel_q = '0;
  string pend_tag = "";

  always #10 clk = ~clk;

  pipe_hazard_unit #(.NUM_SRC(NS), .REG_W(RW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .id_src_i(src), .ex_rd_i(ex_rd), .ex_we_i(ex_we),
    .ex_load_i(ex_ld), .mem_rd_i(mem_rd), .mem_we_i(mem_we), .mem_br_taken_i(br),
    .fwd_sel_o(sel), .if_hold_o(if_hold), .id_hold_o(id_hold), .ex_bubble_o(ex_bub),
    .if_flush_o(if_fl), .id_flush_o(id_fl), .ex_flush_o(ex_fl)
  );

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_stall();
    bit s = 0;
    for (int k = 0; k < NS; k++)
      if (src[k] != 0 && ex_we && ex_ld && ex_rd == src[k]) s = 1;
    return s && !br;
  endfunction

  function automatic logic [1:0] exp_next(input int k);
    if (exp_stall() || br) return 2'b00;
    if (src[k] != 0 && ex_we && ex_rd == src[k]) return 2'b01;
    if (src[k] != 0 && mem_we && mem_rd == src[k]) return 2'b10;
    return 2'b00;
  endfunction

  // one pipeline cycle: check registered selects, drive, check combinational outputs
  task automatic step(input logic [RW-1:0] s0, input logic [RW-1:0] s1,
                      input logic [RW-1:0] erd, input logic ewe, input logic eld,
                      input logic [RW-1:0] mrd, input logic mwe, input logic b,
                      input string tag);
    logic [NS-1:0][1:0] nxt;
    @(negedge clk);
    for (int k = 0; k < NS; k++) begin
      string t;
      if (pend_tag != "") t = pend_tag;
      else if (exp_sel_q[k] == 2'b01) t = "R1";
      else if (exp_sel_q[k] == 2'b10) t = "R2";
      else t = "R8";
      chk(t, $sformatf("fwd_sel[%0d]", k), {6'd0, sel[k]}, {6'd0, exp_sel_q[k]});
    end
    src[0] = s0; src[1] = s1; ex_rd = erd; ex_we = ewe; ex_ld = eld;
    mem_rd = mrd; mem_we = mwe; br = b;
    #2;
    chk(b ? "R7" : "R5", "hold/bubble", {5'd0, if_hold, id_hold, ex_bub},
        {5'd0, {3{exp_stall()}}});
    chk("R7", "flush", {5'd0, if_fl, id_fl, ex_fl}, {5'd0, {3{b}}});
    for (int k = 0; k < NS; k++) nxt[k] = exp_next(k);
    exp_sel_q = nxt;
    pend_tag = tag;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #15;
    chk("R9", "fwd_sel in reset", {4'd0, sel}, 8'd0);
    // a matching pattern during reset must not load the selects
    src[0] = 5'd3; ex_rd = 5'd3; ex_we = 1'b1;
    @(posedge clk); #3;
    chk("R9", "fwd_sel held in reset", {4'd0, sel}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    src = '0; ex_we = 0;

    // directed cases
    step(5'd3, 5'd9, 5'd3, 1, 0, 5'd0, 0, 0, "R1");   // execute match -> memory bypass
    step(5'd7, 5'd4, 5'd1, 1, 0, 5'd4, 1, 0, "R2");   // memory match -> write-back bypass
    step(5'd6, 5'd6, 5'd6, 1, 0, 5'd6, 1, 0, "R3");   // both match -> newer wins
    step(5'd0, 5'd0, 5'd0, 1, 1, 5'd0, 1, 0, "R4");   // register 0 with writing load
    step(5'd5, 5'd2, 5'd5, 0, 0, 5'd2, 0, 0, "R8");   // no writer -> register file
    // load-use: stall, bubble, then write-back bypass
    step(5'd8, 5'd1, 5'd8, 1, 1, 5'd0, 0, 0, "R6");
    step(5'd8, 5'd1, 5'd0, 0, 0, 5'd8, 1, 0, "R6");
    step(5'd0, 5'd0, 5'd0, 0, 0, 5'd0, 0, 0, "R5");
    // load-use coinciding with a taken transfer
    step(5'd9, 5'd9, 5'd9, 1, 1, 5'd9, 1, 1, "R7");
    step(5'd0, 5'd0, 5'd0, 0, 0, 5'd0, 0, 0, "R7");
    // register 0 against load in execute on the second source
    step(5'd2, 5'd0, 5'd0, 1, 1, 5'd0, 1, 0, "R4");

    // constrained random: small register range for frequent matches
    for (int i = 0; i < 600; i++) begin
      step(RW'($urandom_range(0, 3)), RW'($urandom_range(0, 3)),
           RW'($urandom_range(0, 3)), 1'($urandom), 1'($urandom_range(0, 3) == 0),
           RW'($urandom_range(0, 3)), 1'($urandom), 1'($urandom_range(0, 7) == 0), "");
    end
    step(5'd0, 5'd0, 5'd0, 0, 0, 5'd0, 0, 0, "");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule